// File: doc/BRIEF.md
# Synthesiser Divider, Phase Detector and Lock Monitor

This block is the digital heart of a charge-pump frequency synthesiser. A reference clock and a local-oscillator (LO) clock arrive as single-cycle tick enables in the system clock domain. Each is divided down to a comparison rate. The reference path uses a two-ratio counter. The LO path uses a dual-modulus pulse-swallow counter built from a prescaler, a program counter and a swallow counter.

A three-state phase-frequency detector compares the two divided pulses and issues pump-up or pump-down commands. A two-bit override code can force the pump either way or float it. A modulation request freezes the pump in the floating state, but only once the detector has gone idle.

A lock monitor measures the widths of the up and down pulses over each comparison period. It raises a lock flag after a run of quiet periods. The lock flag can also be steered onto the receive data pin whenever the synthesiser is on and neither the receiver nor the transmitter is enabled.

Top module: `synth_core`

## Requirements
- R1: With `ref_tick` held high, `ref_div_out` pulses once every 6 clocks when `cfg_ref_sel`=0 and once every 8 clocks when `cfg_ref_sel`=1. Every pulse follows a cycle in which `ref_tick` was high.
- R2: With `lo_tick` held high, `lo_div_out` pulses once every M·N+A clocks. N is `PRESC_N` (default 32). M is 32 when `cfg_m_sel`=0 and 34 when `cfg_m_sel`=1. A is `cfg_a`, in the range 0..31. Every pulse follows a cycle with `lo_tick` high.
- R3: A new `cfg_m_sel` or `cfg_a` value is captured only on the clock edge that produces an LO divider pulse. The LO period already in progress keeps its old length.
- R4: Consider code 00 with no modulation hold. A divided reference pulse arriving first raises `cp_up` from the next cycle until a divided LO pulse arrives. An LO pulse arriving first raises `cp_dn` in the same way. The arrival of the opposite pulse clears both. Coincident pulses produce neither output. The detector never drives up and down together.
- R5: `cfg_cpc` acts combinationally, with no clock edge needed. 00 passes the detector through. 01 forces `cp_dn`. 10 forces `cp_up`. 11 drives neither. `cp_hiz` is high whenever neither `cp_up` nor `cp_dn` is high. The forcing codes override the modulation hold.
- R6: While `mod_req` is high, the hold engages only on an edge at which the detector is idle. A pump pulse already in progress therefore ends normally. Once the hold is engaged, code 00 leaves the pump floating even when the detector pulses. Lowering `mod_req` releases the hold on the next edge.
- R7: At each divided reference pulse, the period just ended counts as locked when its longest up pulse and its longest down pulse are both shorter than `lock_thr` clocks. `lock` rises on the `LOCK_CYCLES`-th consecutive locked period and stays high while periods remain locked. Any unlocked period clears `lock` and restarts the count. `lock` changes only one cycle after a divided reference pulse.
- R8: `drx` is registered. It carries `lock` when `syn_on`=1, `rx_on`=0 and `tx_on`=0, and carries `rx_data` otherwise.
- R9: After reset, `cp_up`, `cp_dn`, `lock`, `drx` and both divider outputs are 0, and `cp_hiz` is 1 with code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable per reference clock edge |
| lo_tick | input | 1 | One-cycle enable per LO clock edge |
| cfg_ref_sel | input | 1 | Reference ratio select: 0 gives 6, 1 gives 8 |
| cfg_m_sel | input | 1 | Program count select: 0 gives 32, 1 gives 34 |
| cfg_a | input | A_W | Swallow count A |
| cfg_cpc | input | 2 | Pump override code |
| mod_req | input | 1 | Modulation request, holds the pump floating |
| lock_thr | input | THR_W | Pulse-width limit for a locked period, in clocks |
| syn_on | input | 1 | Synthesiser powered |
| rx_on | input | 1 | Receiver enabled |
| tx_on | input | 1 | Transmitter enabled |
| rx_data | input | 1 | Demodulated receive data |
| ref_div_out | output | 1 | Divided reference pulse |
| lo_div_out | output | 1 | Divided LO pulse |
| cp_up | output | 1 | Pump-up command |
| cp_dn | output | 1 | Pump-down command |
| cp_hiz | output | 1 | Pump floating |
| lock | output | 1 | Lock detected |
| drx | output | 1 | Receive data pin, or lock when idle |

## Verification
The bench builds the block with `PRESC_N`=4 and `LOCK_CYCLES`=8, keeping the defaults for everything else. With these values, an LO comparison period is 128 to 167 clocks. Many complete divider periods, a full lock acquisition, a lock held through a small phase step and a loss of lock after a large one therefore all fit into a short run. The program counts 32 and 34 and the full 5-bit swallow range remain unchanged, so the M·N+A arithmetic and the swallow-count boundary are exercised as in the default build.

// File: rtl/synth_pkg.sv
package synth_pkg;
  typedef enum logic [1:0] {
    CP_NORMAL   = 2'b00,
    CP_FORCE_DN = 2'b01,
    CP_FORCE_UP = 2'b10,
    CP_FLOAT    = 2'b11
  } cp_mode_e;
endpackage

// File: rtl/synth_ref_div.sv
module synth_ref_div #(
  parameter int R_LO = 6,
  parameter int R_HI = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sel,
  output logic fb
);
  localparam int CW = $clog2(R_HI);
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = sel ? CW'(R_HI - 1) : CW'(R_LO - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      fb  <= 1'b0;
    end else begin
      fb <= 1'b0;
      if (tick) begin
        if (cnt >= last) begin
          cnt <= '0;
          fb  <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/synth_lo_div.sv
module synth_lo_div #(
  parameter int PRESC_N = 32,
  parameter int M_LO    = 32,
  parameter int M_HI    = 34,
  parameter int A_W     = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           m_sel,
  input  logic [A_W-1:0] a_val,
  output logic           fb
);
  localparam int PW = $clog2(PRESC_N + 1);
  localparam int MW = $clog2(M_HI);

  logic [PW-1:0]  pres;
  logic [MW-1:0]  prog;
  logic [MW-1:0]  m_last;
  logic [A_W-1:0] swal;
  logic [PW-1:0]  pres_last;
  logic           pres_wrap;
  logic           term;
  logic [MW-1:0]  m_new;

  assign m_new     = m_sel ? MW'(M_HI - 1) : MW'(M_LO - 1);
  assign pres_last = (swal != '0) ? PW'(PRESC_N) : PW'(PRESC_N - 1);
  assign pres_wrap = tick && (pres == pres_last);
  assign term      = pres_wrap && (prog == m_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      pres   <= '0;
      prog   <= '0;
      swal   <= a_val;
      m_last <= m_new;
      fb     <= 1'b0;
    end else begin
      fb <= term;
      if (tick) begin
        if (pres_wrap) begin
          pres <= '0;
          if (term) begin
            prog   <= '0;
            swal   <= a_val;
            m_last <= m_new;
          end else begin
            prog <= prog + 1'b1;
            if (swal != '0) swal <= swal - 1'b1;
          end
        end else begin
          pres <= pres + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/synth_pfd.sv
module synth_pfd
  import synth_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_fb,
  input  logic       lo_fb,
  input  logic       mod_req,
  input  logic [1:0] cpc,
  output logic       pfd_up,
  output logic       pfd_dn,
  output logic       cp_up,
  output logic       cp_dn,
  output logic       cp_hiz
);
  logic nxt_up, nxt_dn, hold;

  assign nxt_up = pfd_up | ref_fb;
  assign nxt_dn = pfd_dn | lo_fb;

  always_ff @(posedge clk) begin
    if (rst) begin
      pfd_up <= 1'b0;
      pfd_dn <= 1'b0;
      hold   <= 1'b0;
    end else begin
      if (nxt_up && nxt_dn) begin
        pfd_up <= 1'b0;
        pfd_dn <= 1'b0;
      end else begin
        pfd_up <= nxt_up;
        pfd_dn <= nxt_dn;
      end
      if (!mod_req)                   hold <= 1'b0;
      else if (!pfd_up && !pfd_dn)    hold <= 1'b1;
    end
  end

  // Override codes bypass the clock on purpose.
  always_comb begin
    cp_up = 1'b0;
    cp_dn = 1'b0;
    unique case (cp_mode_e'(cpc))
      CP_NORMAL: begin
        cp_up = pfd_up & ~hold;
        cp_dn = pfd_dn & ~hold;
      end
      CP_FORCE_DN: cp_dn = 1'b1;
      CP_FORCE_UP: cp_up = 1'b1;
      CP_FLOAT:    ;
      default:     ;
    endcase
    cp_hiz = ~(cp_up | cp_dn);
  end
endmodule

// File: rtl/synth_lock_det.sv
module synth_lock_det #(
  parameter int LOCK_CYCLES = 256,
  parameter int THR_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_fb,
  input  logic             up,
  input  logic             dn,
  input  logic [THR_W-1:0] thr,
  output logic             lock
);
  localparam int LW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [LW-1:0]    LAST = LW'(LOCK_CYCLES - 1);
  localparam logic [THR_W-1:0] WMAX = {THR_W{1'b1}};

  logic [THR_W-1:0] wu, wd, pu, pd, wu_n, wd_n, pu_n, pd_n;
  logic [LW-1:0]    run;
  logic             cyc_ok;

  always_comb begin
    wu_n   = up ? ((wu == WMAX) ? wu : wu + 1'b1) : '0;
    wd_n   = dn ? ((wd == WMAX) ? wd : wd + 1'b1) : '0;
    pu_n   = (wu_n > pu) ? wu_n : pu;
    pd_n   = (wd_n > pd) ? wd_n : pd;
    cyc_ok = (pu_n < thr) && (pd_n < thr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wu <= '0; wd <= '0; pu <= '0; pd <= '0;
      run <= '0;
      lock <= 1'b0;
    end else begin
      wu <= wu_n;
      wd <= wd_n;
      if (ref_fb) begin
        pu <= wu_n;
        pd <= wd_n;
        if (cyc_ok) begin
          if (run == LAST) lock <= 1'b1;
          else             run  <= run + 1'b1;
        end else begin
          run  <= '0;
          lock <= 1'b0;
        end
      end else begin
        pu <= pu_n;
        pd <= pd_n;
      end
    end
  end
endmodule

// File: rtl/synth_core.sv
module synth_core #(
  parameter int PRESC_N     = 32,
  parameter int M_LO        = 32,
  parameter int M_HI        = 34,
  parameter int R_LO        = 6,
  parameter int R_HI        = 8,
  parameter int A_W         = 5,
  parameter int THR_W       = 8,
  parameter int LOCK_CYCLES = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             lo_tick,
  input  logic             cfg_ref_sel,
  input  logic             cfg_m_sel,
  input  logic [A_W-1:0]   cfg_a,
  input  logic [1:0]       cfg_cpc,
  input  logic             mod_req,
  input  logic [THR_W-1:0] lock_thr,
  input  logic             syn_on,
  input  logic             rx_on,
  input  logic             tx_on,
  input  logic             rx_data,
  output logic             ref_div_out,
  output logic             lo_div_out,
  output logic             cp_up,
  output logic             cp_dn,
  output logic             cp_hiz,
  output logic             lock,
  output logic             drx
);
  logic ref_fb, lo_fb, pfd_up, pfd_dn;

  synth_ref_div #(.R_LO(R_LO), .R_HI(R_HI)) u_ref (
    .clk(clk), .rst(rst), .tick(ref_tick), .sel(cfg_ref_sel), .fb(ref_fb));

  synth_lo_div #(.PRESC_N(PRESC_N), .M_LO(M_LO), .M_HI(M_HI), .A_W(A_W)) u_lo (
    .clk(clk), .rst(rst), .tick(lo_tick), .m_sel(cfg_m_sel), .a_val(cfg_a), .fb(lo_fb));

  synth_pfd u_pfd (
    .clk(clk), .rst(rst), .ref_fb(ref_fb), .lo_fb(lo_fb), .mod_req(mod_req),
    .cpc(cfg_cpc), .pfd_up(pfd_up), .pfd_dn(pfd_dn),
    .cp_up(cp_up), .cp_dn(cp_dn), .cp_hiz(cp_hiz));

  synth_lock_det #(.LOCK_CYCLES(LOCK_CYCLES), .THR_W(THR_W)) u_lock (
    .clk(clk), .rst(rst), .ref_fb(ref_fb), .up(pfd_up), .dn(pfd_dn),
    .thr(lock_thr), .lock(lock));

  assign ref_div_out = ref_fb;
  assign lo_div_out  = lo_fb;

  always_ff @(posedge clk) begin
    if (rst) drx <= 1'b0;
    else     drx <= (syn_on && !rx_on && !tx_on) ? lock : rx_data;
  end
endmodule

// File: rtl/synth_core_chk.sv
module synth_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       ref_tick,
  input logic       lo_tick,
  input logic       ref_fb,
  input logic       lo_fb,
  input logic       pfd_up,
  input logic       pfd_dn,
  input logic [1:0] cpc,
  input logic       cp_up,
  input logic       cp_dn,
  input logic       cp_hiz,
  input logic       lock,
  input logic       drx,
  input logic       syn_on,
  input logic       rx_on,
  input logic       tx_on
);
  // R1
  ref_pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    ref_fb |-> $past(ref_tick));
  // R2
  lo_pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    lo_fb |-> $past(lo_tick));
  // R4
  pfd_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(pfd_up && pfd_dn));
  // R5
  cp_float_chk: assert property (@(posedge clk) disable iff (rst)
    (cpc == 2'b11) |-> (!cp_up && !cp_dn && cp_hiz));
  // R5
  cp_force_dn_chk: assert property (@(posedge clk) disable iff (rst)
    (cpc == 2'b01) |-> (cp_dn && !cp_up && !cp_hiz));
  // R6
  mod_no_cut_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(cp_up) && cpc == 2'b00 && $past(cpc) == 2'b00) |-> !pfd_up);
  // R7
  lock_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    (lock != $past(lock)) |-> $past(ref_fb));
  // R8
  drx_route_chk: assert property (@(posedge clk) disable iff (rst)
    $past(syn_on && !rx_on && !tx_on) |-> (drx == $past(lock)));
endmodule

bind synth_core synth_core_chk u_chk (
  .clk(clk), .rst(rst), .ref_tick(ref_tick), .lo_tick(lo_tick),
  .ref_fb(ref_fb), .lo_fb(lo_fb), .pfd_up(pfd_up), .pfd_dn(pfd_dn),
  .cpc(cfg_cpc), .cp_up(cp_up), .cp_dn(cp_dn), .cp_hiz(cp_hiz),
  .lock(lock), .drx(drx), .syn_on(syn_on), .rx_on(rx_on), .tx_on(tx_on));

// File: tb/synth_core_tb.sv
`timescale 1ns/1ps
module synth_core_tb;
  localparam int PN = 4;
  localparam int LC = 8;
  localparam int AW = 5;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0, lo_tick = 1'b0;
  logic cfg_ref_sel = 1'b0, cfg_m_sel = 1'b0;
  logic [AW-1:0] cfg_a = '0;
  logic [1:0] cfg_cpc = 2'b00;
  logic mod_req = 1'b0;
  logic [TW-1:0] lock_thr = 8'd4;
  logic syn_on = 1'b1, rx_on = 1'b0, tx_on = 1'b0, rx_data = 1'b0;
  logic ref_div_out, lo_div_out, cp_up, cp_dn, cp_hiz, lock, drx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int pc = 0;

  always #2.5 clk = ~clk;

  synth_core #(.PRESC_N(PN), .LOCK_CYCLES(LC), .A_W(AW), .THR_W(TW)) u_dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .lo_tick(lo_tick),
    .cfg_ref_sel(cfg_ref_sel), .cfg_m_sel(cfg_m_sel), .cfg_a(cfg_a),
    .cfg_cpc(cfg_cpc), .mod_req(mod_req), .lock_thr(lock_thr),
    .syn_on(syn_on), .rx_on(rx_on), .tx_on(tx_on), .rx_data(rx_data),
    .ref_div_out(ref_div_out), .lo_div_out(lo_div_out), .cp_up(cp_up),
    .cp_dn(cp_dn), .cp_hiz(cp_hiz), .lock(lock), .drx(drx));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog: run hung, actual=%0d expected<=150000", cyc);
      errors = errors + 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int exp_lo(input logic msel, input int a);
    return (msel ? 34 : 32) * PN + a;
  endfunction

  function automatic int exp_cp(input logic [1:0] code);
    // returns {up,dn} with detector idle
    case (code)
      2'b01:   return 1;
      2'b10:   return 2;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_ref();
    do @(negedge clk); while (!ref_div_out);
  endtask

  task automatic wait_lo();
    do @(negedge clk); while (!lo_div_out);
  endtask

  task automatic period_lo(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!lo_div_out);
  endtask

  task automatic period_ref(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!ref_div_out);
  endtask

  task automatic step_aligned(input int n);
    repeat (n) begin
      @(negedge clk);
      ref_tick = ((pc % 16) == 15);
      lo_tick = 1'b1;
      pc++;
    end
  endtask

  task automatic lo_gap(input int n);
    repeat (n) begin
      @(negedge clk);
      ref_tick = ((pc % 16) == 15);
      lo_tick = 1'b0;
      pc++;
    end
  endtask

  initial begin
    int p, a0, a1, v;
    logic ms;
    logic [1:0] code;
    void'($urandom(32'h5EED_0042));
    do_reset();
    @(negedge clk);
    // R9 reset state
    chk(!cp_up && !cp_dn && cp_hiz, "R9 pump idle", {cp_up, cp_dn, cp_hiz}, 1);
    chk(!lock && !drx && !ref_div_out && !lo_div_out, "R9 flags low",
        {lock, drx, ref_div_out, lo_div_out}, 0);

    // R1 reference ratios
    ref_tick = 1'b1;
    for (int i = 0; i < 4; i++) begin
      cfg_ref_sel = i[0];
      wait_ref();
      period_ref(p);
      chk(p == (i[0] ? 8 : 6), "R1 ref period", p, i[0] ? 8 : 6);
    end
    ref_tick = 1'b0;

    // R2 LO ratios: directed extremes then random
    lo_tick = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (i == 0)      begin ms = 1'b0; v = 0;  end
      else if (i == 1) begin ms = 1'b1; v = 31; end
      else begin ms = 1'($urandom); v = int'($urandom % 32); end
      cfg_m_sel = ms; cfg_a = AW'(v);
      wait_lo();
      period_lo(p);
      chk(p == exp_lo(ms, v), "R2 lo period", p, exp_lo(ms, v));
    end

    // R3 change mid-period
    a0 = 3; a1 = 17; ms = 1'b0;
    cfg_m_sel = ms; cfg_a = AW'(a0);
    wait_lo();
    wait_lo();
    @(negedge clk);
    cfg_a = AW'(a1);
    cfg_m_sel = 1'b1;
    p = 1;
    while (!lo_div_out) begin @(negedge clk); p++; end
    chk(p == exp_lo(1'b0, a0), "R3 current period keeps old", p, exp_lo(1'b0, a0));
    period_lo(p);
    chk(p == exp_lo(1'b1, a1), "R3 next period uses new", p, exp_lo(1'b1, a1));
    lo_tick = 1'b0;
    cfg_m_sel = 1'b0; cfg_a = '0;

    // R4 detector
    do_reset();
    ref_tick = 1'b1; wait_ref(); ref_tick = 1'b0;
    @(negedge clk);
    chk(cp_up && !cp_dn, "R4 ref first gives up", {cp_up, cp_dn}, 2);
    lo_tick = 1'b1; wait_lo(); lo_tick = 1'b0;
    @(negedge clk);
    chk(!cp_up && !cp_dn && cp_hiz, "R4 up cleared by lo", {cp_up, cp_dn, cp_hiz}, 1);
    lo_tick = 1'b1; wait_lo(); lo_tick = 1'b0;
    @(negedge clk);
    chk(cp_dn && !cp_up, "R4 lo first gives dn", {cp_up, cp_dn}, 1);
    ref_tick = 1'b1; wait_ref(); ref_tick = 1'b0;
    @(negedge clk);
    chk(!cp_up && !cp_dn, "R4 dn cleared by ref", {cp_up, cp_dn}, 0);

    // R6 modulation hold
    ref_tick = 1'b1; wait_ref(); ref_tick = 1'b0;
    @(negedge clk);
    mod_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(cp_up == 1'b1, "R6 pulse in progress not cut", cp_up, 1);
    lo_tick = 1'b1; wait_lo(); lo_tick = 1'b0;
    @(negedge clk);
    ref_tick = 1'b1; wait_ref(); ref_tick = 1'b0;
    @(negedge clk);
    chk(!cp_up && cp_hiz, "R6 held pump floats", {cp_up, cp_hiz}, 1);
    cfg_cpc = 2'b10; #1;
    chk(cp_up == 1'b1, "R5 force up overrides hold", cp_up, 1);
    @(negedge clk);
    cfg_cpc = 2'b00;
    mod_req = 1'b0;
    @(negedge clk);
    chk(cp_up == 1'b1, "R6 release restores pump", cp_up, 1);
    lo_tick = 1'b1; wait_lo(); lo_tick = 1'b0;
    @(negedge clk);

    // R5 override codes, combinational
    cfg_cpc = 2'b01; #1;
    chk(cp_dn && !cp_up, "R5 code 01 forces dn", {cp_up, cp_dn}, 1);
    cfg_cpc = 2'b11; #1;
    chk(!cp_up && !cp_dn && cp_hiz, "R5 code 11 floats", {cp_up, cp_dn, cp_hiz}, 1);
    for (int i = 0; i < 6; i++) begin
      code = 2'($urandom);
      cfg_cpc = code; #1;
      v = {cp_up, cp_dn};
      chk(v == exp_cp(code) && cp_hiz == (v == 0), "R5 random code", v, exp_cp(code));
    end
    cfg_cpc = 2'b00;
    @(negedge clk);

    // R7 lock acquisition with aligned stream
    cfg_ref_sel = 1'b1; cfg_m_sel = 1'b0; cfg_a = '0; lock_thr = 8'd4;
    do_reset();
    pc = 0;
    step_aligned(6 * 128);
    chk(lock == 1'b0, "R7 no lock before interval", lock, 0);
    step_aligned(5 * 128);
    chk(lock == 1'b1, "R7 lock after interval", lock, 1);
    chk(drx == 1'b1, "R8 drx carries lock when idle", drx, 1);
    rx_on = 1'b1; rx_data = 1'b0;
    step_aligned(2);
    chk(drx == 1'b0, "R8 drx carries rx data", drx, 0);
    rx_data = 1'b1;
    step_aligned(2);
    chk(drx == 1'b1, "R8 drx follows rx data", drx, 1);
    rx_on = 1'b0; rx_data = 1'b0;
    lo_gap(2);
    step_aligned(4 * 128);
    chk(lock == 1'b1, "R7 small offset keeps lock", lock, 1);
    lo_gap(20);
    step_aligned(2 * 128);
    chk(lock == 1'b0, "R7 large offset drops lock", lock, 0);
    step_aligned(10 * 128);
    chk(lock == 1'b0, "R7 stays unlocked", lock, 0);
    chk(drx == 1'b0, "R8 drx shows no lock", drx, 0);
    ref_tick = 1'b0; lo_tick = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule